// File: doc/BRIEF.md
# Two-Port Fair Priority Arbiter

This block picks one of two requesters every clock cycle and returns a one-hot grant in that same cycle. The grant is formed combinationally from the current request lines and a small amount of registered history. Port 0 is the preferred requester. Per-port run limits stop either side from holding the grant for too long while the other side is waiting.

Each port has a saturating counter of consecutive cycles in which it was granted. A port whose counter has reached its limit gives way when both ports request. A port that requests alone is always granted, even past its limit, so no cycle with a pending request is left idle. Any cycle in which a port is not granted clears that port's counter. With the default limits of three cycles for port 0 and one cycle for port 1, continuous contention yields the repeating grant order 0, 0, 0, 1.

Top module: `fair_arb2`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears all grant history, so the first contested cycle after reset grants port 0.
- R2: When req_i is 2'b00, gnt_o is 2'b00 in that cycle.
- R3: When req_i is nonzero, exactly one bit of gnt_o is high in that same cycle, and it belongs to a requesting port (bit 0 is port 0, bit 1 is port 1).
- R4: When only one port requests, that port is granted: req_i 2'b01 gives gnt_o 2'b01, and req_i 2'b10 gives gnt_o 2'b10.
- R5: When both ports request and port 0 has been granted fewer than MAX_RUN0 consecutive cycles, port 0 is granted (gnt_o 2'b01).
- R6: When both ports request after port 0 has been granted MAX_RUN0 consecutive cycles (default 3), port 1 is granted (gnt_o 2'b10).
- R7: When both ports request after port 1 has been granted MAX_RUN1 consecutive cycles (default 1), port 0 is granted.
- R8: With req_i held at 2'b11, gnt_o repeats the pattern 01, 01, 01, 10 starting from cleared history.
- R9: A sole requester is granted even when its run limit has been reached, and its run still counts: after five cycles of port 0 alone, a contested cycle grants port 1.
- R10: A cycle in which a port is not granted, including an idle cycle, clears that port's run, so its next contested streak may again last MAX_RUN cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Request lines, bit 0 is port 0 |
| gnt_o | output | 2 | One-hot grant, same cycle as the request |

## Verification
The bench builds the arbiter with its default limits, three consecutive wins for port 0 and one for port 1. These short limits bring both saturation points within a few cycles, so the full repeating contention pattern, a sole requester running past its limit and then meeting contention, and an idle cycle breaking a streak part way through are all reached in short directed sequences.

// File: rtl/fair_arb_pkg.sv
package fair_arb_pkg;
  localparam int unsigned NUM_PORTS = 2;
  typedef logic [NUM_PORTS-1:0] port_vec_t;

  localparam port_vec_t PICK_NONE = 2'b00;
  localparam port_vec_t PICK_P0   = 2'b01;
  localparam port_vec_t PICK_P1   = 2'b10;

  function automatic int unsigned run_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/arb_run_cnt.sv
module arb_run_cnt #(
  parameter int unsigned MAX_RUN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic won_i,
  output logic at_limit_o
);
  localparam int unsigned CW = fair_arb_pkg::run_width(MAX_RUN);
  localparam logic [CW-1:0] LIM = CW'(MAX_RUN);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (!won_i)             run_d = '0;
    else if (run_q == LIM)  run_d = run_q;  // saturate
    else                    run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign at_limit_o = (run_q == LIM);

  // R6
  run_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LIM);

  // R10
  run_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !won_i |=> !at_limit_o);
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import fair_arb_pkg::*;
(
  input  port_vec_t req_i,
  input  logic      lim0_i,
  input  logic      lim1_i,
  output port_vec_t gnt_o
);
  always_comb begin
    unique case (req_i)
      2'b01:   gnt_o = PICK_P0;
      2'b10:   gnt_o = PICK_P1;
      2'b11:   gnt_o = (lim0_i && !lim1_i) ? PICK_P1 : PICK_P0;
      default: gnt_o = PICK_NONE;
    endcase
  end

  always_comb begin
    // R3
    gnt_in_req_chk: assert ((gnt_o & ~req_i) == '0);
  end
endmodule

// File: rtl/fair_arb2.sv
module fair_arb2
  import fair_arb_pkg::*;
#(
  parameter int unsigned MAX_RUN0 = 3,
  parameter int unsigned MAX_RUN1 = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic [NUM_PORTS-1:0] at_limit;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_run
    arb_run_cnt #(
      .MAX_RUN(g == 0 ? MAX_RUN0 : MAX_RUN1)
    ) u_run (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .won_i     (gnt_o[g]),
      .at_limit_o(at_limit[g])
    );
  end

  arb_pick u_pick (
    .req_i (req_i),
    .lim0_i(at_limit[0]),
    .lim1_i(at_limit[1]),
    .gnt_o (gnt_o)
  );

  // checker-side streak counters, kept apart from the design counters
  localparam int unsigned KW0 = run_width(MAX_RUN0);
  localparam int unsigned KW1 = run_width(MAX_RUN1);
  logic [KW0-1:0] chk_run0;
  logic [KW1-1:0] chk_run1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_run0 <= '0;
      chk_run1 <= '0;
    end else begin
      chk_run0 <= !gnt_o[0] ? '0 : (chk_run0 == KW0'(MAX_RUN0)) ? chk_run0 : chk_run0 + 1'b1;
      chk_run1 <= !gnt_o[1] ? '0 : (chk_run1 == KW1'(MAX_RUN1)) ? chk_run1 : chk_run1 + 1'b1;
    end
  end

  // R2
  idle_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b00) |-> (gnt_o == 2'b00));

  // R3
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != 2'b00) |-> ($countones(gnt_o) == 1));

  // R5
  p0_pref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && chk_run0 < KW0'(MAX_RUN0)) |-> gnt_o[0]);

  // R6
  p0_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && chk_run0 == KW0'(MAX_RUN0)) |-> gnt_o[1]);

  // R7
  p1_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && chk_run1 == KW1'(MAX_RUN1)) |-> gnt_o[0]);
endmodule

// File: tb/sim_fair_arb2.sv
module sim_fair_arb2;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = 2'b00;
  logic [1:0] gnt;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  fair_arb2 u0 (
    .clk_i (clk),
    .rst_ni(rst_n),
    .req_i (req),
    .gnt_o (gnt)
  );

  task automatic drive(input logic [1:0] r, input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req = r;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: samples mid low phase, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (gnt !== it.exp) begin
          errors++;
          $display("FAIL %s: gnt=%b expected %b", it.tag, gnt, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: idle after reset
    drive(2'b00, 2'b00, "R2");
    // R1: first contested cycle after reset; then R8 steady pattern (R5/R6/R7)
    for (int i = 0; i < 12; i++)
      drive(2'b11, (i % 4 == 3) ? 2'b10 : 2'b01, (i == 0) ? "R1" : "R8");
    drive(2'b00, 2'b00, "R2");
    // R4: sole requesters, R3 exact one-hot
    drive(2'b01, 2'b01, "R4");
    drive(2'b10, 2'b10, "R4");
    // R7: port 1 just won
    drive(2'b11, 2'b01, "R7");
    drive(2'b00, 2'b00, "R2");
    // R9: port 0 alone past its limit, then contention
    for (int i = 0; i < 5; i++) drive(2'b01, 2'b01, "R9");
    drive(2'b11, 2'b10, "R9");
    drive(2'b00, 2'b00, "R2");
    // R10: idle breaks a streak part way
    drive(2'b11, 2'b01, "R10");
    drive(2'b11, 2'b01, "R10");
    drive(2'b00, 2'b00, "R10");
    for (int i = 0; i < 3; i++) drive(2'b11, 2'b01, "R10");
    drive(2'b11, 2'b10, "R6");
    drive(2'b00, 2'b00, "R2");
    // R9: port 1 alone past its limit, then contention goes to port 0
    for (int i = 0; i < 3; i++) drive(2'b10, 2'b10, "R9");
    drive(2'b11, 2'b01, "R7");
    // R10: skipped cycle for port 0 via port 1 alone
    drive(2'b11, 2'b01, "R5");
    drive(2'b10, 2'b10, "R10");
    for (int i = 0; i < 3; i++) drive(2'b11, 2'b01, "R10");
    drive(2'b11, 2'b10, "R6");
    // R1: reset mid streak clears history
    drive(2'b11, 2'b01, "R5");
    drive(2'b11, 2'b01, "R5");
    @(negedge clk);
    #4;
    rst_n = 1'b0;
    req = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(2'b11, (i == 3) ? 2'b10 : 2'b01, "R1");
    drive(2'b00, 2'b00, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule